// File: doc/BRIEF.md
# Sigma-Delta Conversion Sequencer

This block decides which outputs of a sigma-delta decimation filter count as finished conversions. The filter emits a strobe with a data word each time it produces a sample. A digital filter of this kind needs four samples before its output reflects a new input, so the sequencer throws away the early samples after every (re)start. In single-shot mode exactly one result comes out per start command and the block then goes quiet. In continuous mode every sample after the settling window is passed on.

Each accepted result sets a sticky done flag. A status-read strobe clears it. The done flag is steered either to a dedicated interrupt line or to one of several general-purpose pins. A digital signal-detect input from an analog comparator is latched into the dedicated interrupt line. A threshold select code for that comparator passes through the block unchanged.

Top module: `conv_sequencer`

## Requirements
- R1: In single-shot mode (`mode_cont`=0), after a start the first three filter strobes are discarded. The fourth strobe raises `res_valid` for one cycle in the cycle after it is sampled, and `res_data` then equals that strobe's data.
- R2: After a single-shot result the block is idle. Further filter strobes give no `res_valid` and do not set `done` until the next start.
- R3: In continuous mode (`mode_cont`=1), after a start the first three strobes are discarded. Every strobe after them is delivered on `res_valid`/`res_data` one cycle after it is sampled.
- R4: A start while a conversion is running restarts the settling count at zero. A strobe in the same cycle as the start is discarded.
- R5: A change of `mode_cont` while running restarts the settling count. A strobe in the cycle of the change is discarded.
- R6: `done` rises together with each `res_valid` and stays high until a cycle with `status_rd`=1. If a result arrives in that same cycle, the set wins.
- R7: With `route_int`=1, `irq` carries `done` and `gpio_irq` is all zero. With `route_int`=0, bit `pin_sel` of `gpio_irq` carries `done` and all other bits are zero.
- R8: `cmp_in` sampled high makes `irq` high from the next cycle, whatever the routing. It stays high until a `status_rd` cycle in which `cmp_in` is low.
- R9: `thr_out` equals `thr_sel` in the same cycle. The five codes 0..4 stand for 0, 50, 100, 150 and 200 mV.
- R10: While `rst_n` is sampled low, the block goes idle and `res_valid`, `done`, `irq` and `gpio_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_cont | input | 1 | 1 = continuous, 0 = single-shot |
| start | input | 1 | Start pulse; restarts settling |
| filt_valid | input | 1 | Filter output strobe |
| filt_data | input | DATA_W | Filter output word |
| status_rd | input | 1 | Status read; clears done and detect latch |
| route_int | input | 1 | 1 = done to irq, 0 = done to a pin |
| pin_sel | input | SEL_W | Pin index for done when route_int = 0 |
| cmp_in | input | 1 | Signal-detect comparator output |
| thr_sel | input | 3 | Comparator threshold code |
| thr_out | output | 3 | Threshold code to comparator |
| res_valid | output | 1 | One-cycle valid result pulse |
| res_data | output | DATA_W | Latest accepted result |
| done | output | 1 | Sticky conversion-done status |
| irq | output | 1 | Dedicated interrupt line |
| gpio_irq | output | NUM_PINS | Done routed to general-purpose pins |

## Verification
A strobe sampled at one rising edge shows up on `res_valid`, `res_data` and the rise of `done` after that same edge, so these are due one cycle after the strobe is driven. A sampled `cmp_in` reaches `irq` with the same single-register delay. The routing outputs and `thr_out` are combinational and are due in the same cycle as their inputs. The bench drives inputs just after a rising edge and advances its reference model at the next edge. It compares one time unit later, so each expected value lines up with the edge that produced it.

// File: rtl/conv_seq_pkg.sv
// Shared types for the conversion sequencer.
package conv_seq_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/conv_seq_ctrl.sv
// Settling counter and run state.
// Accepts filter strobes only after SETTLE-1 discards following a start or
// a mode change. Assumes start and filt_valid are synchronous single-cycle
// qualifiers.
module conv_seq_ctrl
    import conv_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SETTLE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_cont,
    input  logic              start,
    input  logic              filt_valid,
    input  logic [DATA_W-1:0] filt_data,
    output logic              hit,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             mode_q;
    logic             mode_chg;

    // Detect a mode switch against the previous cycle's mode.
    assign mode_chg = (mode_cont != mode_q);

    // A strobe is accepted when settled and not pre-empted by a restart.
    assign hit = (state == SEQ_RUN) && !start && !mode_chg && filt_valid && (cnt == LAST);

    // Run state, settling count and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            cnt       <= '0;
            mode_q    <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            mode_q    <= mode_cont;
            res_valid <= hit;
            if (hit) res_data <= filt_data;
            if (start) begin
                state <= SEQ_RUN;
                cnt   <= '0;
            end else if (state == SEQ_RUN) begin
                if (mode_chg) begin
                    cnt <= '0;
                end else if (filt_valid) begin
                    if (cnt == LAST) begin
                        if (!mode_cont) state <= SEQ_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R1: a result always follows a sampled filter strobe.
    a_r1_result_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(filt_valid));
    // R2: a single-shot result leaves the sequencer idle.
    a_r2_single_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !mode_q) |-> (state == SEQ_IDLE));
    // R4: a start always leaves a running sequencer with a cleared count.
    a_r4_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == SEQ_RUN && cnt == '0));
    // R5: a mode change while running clears the count.
    a_r5_mode_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && state == SEQ_RUN) |=> (cnt == '0));
endmodule

// File: rtl/conv_seq_status.sv
// Sticky done flag and signal-detect latch. Both are cleared by a status
// read. A set in the same cycle takes priority over the clear.
module conv_seq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic cmp_in,
    input  logic status_rd,
    output logic done,
    output logic det
);
    // Set-dominant sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            det  <= 1'b0;
        end else begin
            if (hit)            done <= 1'b1;
            else if (status_rd) done <= 1'b0;
            if (cmp_in)         det  <= 1'b1;
            else if (status_rd) det  <= 1'b0;
        end
    end

    // R6: done holds until read.
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !status_rd) |=> done);
    // R8: a comparator event is latched.
    a_r8_detect_latched: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_in |=> det);
endmodule

// File: rtl/conv_seq_route.sv
// Steers done to the dedicated interrupt or to one general-purpose pin.
// The detect latch always drives the dedicated line. Out-of-range pin
// indices drive no pin.
module conv_seq_route #(
    parameter int NUM_PINS = 8,
    parameter int SEL_W    = 3
) (
    input  logic                done,
    input  logic                det,
    input  logic                route_int,
    input  logic [SEL_W-1:0]    pin_sel,
    output logic                irq,
    output logic [NUM_PINS-1:0] gpio_irq
);
    // Dedicated line: routed done plus signal detect.
    assign irq = (route_int && done) || det;

    // One decoder leg per pin.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign gpio_irq[p] = done && !route_int && (pin_sel == SEL_W'(p));
    end
endmodule

// File: rtl/conv_sequencer.sv
// Top of the conversion sequencer: control, status and routing, plus the
// comparator threshold passthrough.
module conv_sequencer #(
    parameter int DATA_W   = 16,
    parameter int SETTLE   = 4,
    parameter int NUM_PINS = 8,
    parameter int SEL_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_cont,
    input  logic                start,
    input  logic                filt_valid,
    input  logic [DATA_W-1:0]   filt_data,
    input  logic                status_rd,
    input  logic                route_int,
    input  logic [SEL_W-1:0]    pin_sel,
    input  logic                cmp_in,
    input  logic [2:0]          thr_sel,
    output logic [2:0]          thr_out,
    output logic                res_valid,
    output logic [DATA_W-1:0]   res_data,
    output logic                done,
    output logic                irq,
    output logic [NUM_PINS-1:0] gpio_irq
);
    logic hit;
    logic det;

    // Threshold code goes to the comparator untouched.
    assign thr_out = thr_sel;

    conv_seq_ctrl #(.DATA_W(DATA_W), .SETTLE(SETTLE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_cont(mode_cont), .start(start),
        .filt_valid(filt_valid), .filt_data(filt_data), .hit(hit),
        .res_valid(res_valid), .res_data(res_data)
    );

    conv_seq_status u_status (
        .clk(clk), .rst_n(rst_n), .hit(hit), .cmp_in(cmp_in),
        .status_rd(status_rd), .done(done), .det(det)
    );

    conv_seq_route #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_route (
        .done(done), .det(det), .route_int(route_int), .pin_sel(pin_sel),
        .irq(irq), .gpio_irq(gpio_irq)
    );

    // R6: done only rises with a delivered result.
    a_r6_done_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> res_valid);
    // R7: at most one pin carries done.
    a_r7_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gpio_irq));
    // R7: pins stay quiet while done goes to the dedicated line.
    a_r7_int_path_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        route_int |-> (gpio_irq == '0));
    // R10: nothing is flagged right after reset.
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !done && gpio_irq == '0));
endmodule

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
    localparam int DW = 16;
    localparam int NP = 8;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_cont = 1'b0, start = 1'b0, filt_valid = 1'b0, status_rd = 1'b0;
    logic route_int = 1'b1, cmp_in = 1'b0;
    logic [DW-1:0] filt_data = '0;
    logic [SW-1:0] pin_sel = '0;
    logic [2:0] thr_sel = '0, thr_out;
    logic res_valid, done, irq;
    logic [DW-1:0] res_data;
    logic [NP-1:0] gpio_irq;

    int checks = 0;
    int fails = 0;

    // bench reference state
    bit m_run, m_mode, m_rv, m_done, m_det;
    int m_cnt;
    logic [DW-1:0] m_rd;

    always #5 clk = ~clk;

    conv_sequencer #(.DATA_W(DW), .SETTLE(4), .NUM_PINS(NP), .SEL_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_cont(mode_cont), .start(start),
        .filt_valid(filt_valid), .filt_data(filt_data), .status_rd(status_rd),
        .route_int(route_int), .pin_sel(pin_sel), .cmp_in(cmp_in),
        .thr_sel(thr_sel), .thr_out(thr_out), .res_valid(res_valid),
        .res_data(res_data), .done(done), .irq(irq), .gpio_irq(gpio_irq)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] exp_gpio();
        logic [NP-1:0] g = '0;
        if (m_done && !route_int) g[pin_sel] = 1'b1;
        return g;
    endfunction

    // advance reference model with the inputs sampled at this edge
    task automatic model_step();
        bit hitm;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_mode = 0; m_rv = 0; m_done = 0; m_det = 0; m_rd = '0;
            return;
        end
        hitm = m_run && !start && (mode_cont == m_mode) && filt_valid && m_cnt == 3;
        if (start) begin m_run = 1; m_cnt = 0; end
        else if (m_run) begin
            if (mode_cont != m_mode) m_cnt = 0;
            else if (filt_valid) begin
                if (m_cnt == 3) begin if (!mode_cont) m_run = 0; end
                else m_cnt++;
            end
        end
        m_rv = hitm;
        if (hitm) m_rd = filt_data;
        if (hitm) m_done = 1; else if (status_rd) m_done = 0;
        if (cmp_in) m_det = 1; else if (status_rd) m_det = 0;
        m_mode = mode_cont;
    endtask

    task automatic compare();
        if (!rst_n) return;
        chk(m_mode ? "R3" : "R1", res_valid, m_rv);
        if (m_rv) chk(m_mode ? "R3" : "R1", res_data, m_rd);
        chk("R6", done, m_done);
        chk("R7", gpio_irq, exp_gpio());
        chk("R8", irq, (route_int && m_done) || m_det);
        chk("R9", thr_out, thr_sel);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        compare();
    endtask

    task automatic idle_in();
        start = 0; filt_valid = 0; status_rd = 0; cmp_in = 0;
    endtask

    task automatic strobe(input logic [DW-1:0] d);
        filt_valid = 1; filt_data = d; cyc(); filt_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        mode_cont = 1; filt_valid = 1; cmp_in = 1;
        cyc(); cyc();
        chk("R10", res_valid, 0); chk("R10", done, 0);
        chk("R10", irq, 0); chk("R10", gpio_irq, 0);
        idle_in(); mode_cont = 0;
        #1 rst_n = 1;
        cyc();

        // R1: single shot, fourth strobe only
        start = 1; cyc(); start = 0;
        for (int i = 0; i < 3; i++) begin strobe(DW'(16'h100 + i)); chk("R1", res_valid, 0); end
        strobe(16'hBEEF);
        chk("R1", res_valid, 1); chk("R1", res_data, 16'hBEEF); chk("R6", done, 1);
        // R2: later strobes ignored
        for (int i = 0; i < 6; i++) begin strobe(16'h1234); chk("R2", res_valid, 0); end
        chk("R2", res_data, 16'hBEEF);
        status_rd = 1; cyc(); status_rd = 0; chk("R6", done, 0);
        strobe(16'h4321); chk("R2", done, 0);

        // R4: restart mid-conversion with a strobe in the start cycle
        start = 1; cyc(); start = 0;
        strobe(1); strobe(2);
        start = 1; filt_valid = 1; filt_data = 16'h7777; cyc(); start = 0; filt_valid = 0;
        for (int i = 0; i < 3; i++) begin strobe(16'h0AA0); chk("R4", res_valid, 0); end
        strobe(16'h0C0C); chk("R4", res_valid, 1); chk("R4", res_data, 16'h0C0C);

        // R3: continuous
        mode_cont = 1; start = 1; cyc(); start = 0;
        for (int i = 0; i < 3; i++) begin strobe(16'h5555); chk("R3", res_valid, 0); end
        for (int i = 0; i < 5; i++) begin strobe(DW'(16'h900 + i)); chk("R3", res_data, 16'h900 + i); end

        // R5: mode change restarts settling
        mode_cont = 0; filt_valid = 1; filt_data = 16'h6666; cyc(); filt_valid = 0;
        chk("R5", res_valid, 0);
        for (int i = 0; i < 3; i++) begin strobe(16'h0101); chk("R5", res_valid, 0); end
        strobe(16'hD00D); chk("R5", res_valid, 1); chk("R5", res_data, 16'hD00D);

        // R6: set wins over clear
        start = 1; cyc(); start = 0;
        strobe(1); strobe(2); strobe(3);
        status_rd = 1; strobe(16'h00F0); status_rd = 0; chk("R6", done, 1);

        // R7: each pin in turn
        route_int = 0;
        for (int p = 0; p < NP; p++) begin
            pin_sel = SW'(p); cyc(); chk("R7", gpio_irq, NP'(1) << p); chk("R7", irq, 0);
        end
        route_int = 1; cyc(); chk("R7", gpio_irq, 0); chk("R7", irq, 1);
        status_rd = 1; cyc(); status_rd = 0;

        // R8: detect latch independent of routing
        route_int = 0; cmp_in = 1; cyc(); cmp_in = 0; chk("R8", irq, 1);
        repeat (3) cyc(); chk("R8", irq, 1);
        status_rd = 1; cmp_in = 1; cyc(); chk("R8", irq, 1);
        cmp_in = 0; cyc(); status_rd = 0; chk("R8", irq, 0);

        // R9: every threshold code
        for (int t = 0; t < 5; t++) begin thr_sel = 3'(t); #1 chk("R9", thr_out, t); end

        // random phase
        for (int n = 0; n < 4000; n++) begin
            start      = ($urandom % 25) == 0;
            filt_valid = ($urandom % 2) == 0;
            filt_data  = DW'($urandom);
            status_rd  = ($urandom % 8) == 0;
            cmp_in     = ($urandom % 40) == 0;
            if (($urandom % 150) == 0) mode_cont = ~mode_cont;
            if (($urandom % 30) == 0) route_int = ~route_int;
            pin_sel    = SW'($urandom);
            thr_sel    = 3'($urandom % 5);
            cyc();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule